// File: doc/BRIEF.md
# Serial Program Counter with Half-Adder Increment

This block keeps a 16-bit program counter as a shift register that moves one bit per enabled clock, least significant bit first. On every enabled clock the bit leaving the bottom of the register either passes through a half adder or is replaced by an incoming serial data bit. The half adder has its own carry flip-flop, separate from any datapath carry. After a full pass of 16 enabled clocks, the register holds either the old count plus one or the word that was streamed in for a jump.

A separate parallel output latch drives the memory address bus. It only changes when the end-of-cycle strobe is pulsed, so the address stays steady while the register shifts. An internal bit counter tracks which bit is at the bottom of the register. At bit 0 the half adder is given a carry-in of one, so each pass adds exactly one.

Top module: `pc_serial_inc`

## Requirements
- R1: After reset, the address output is 0x0000, the register is 0, and the next pass of 16 shifts without jump followed by a strobe gives 0x0001.
- R2: A pass of 16 enabled shifts with `jump_sel` low, followed by `addr_latch`, makes `addr` equal to the previous register value plus one, modulo 2^16.
- R3: Incrementing 0xFFFF gives 0x0000. The carry ripples through all 16 bits, one bit per shift.
- R4: A pass of 16 enabled shifts with `jump_sel` high loads the register with `ser_din`, taking bit i of the target on the i-th shift (LSB first). After `addr_latch`, `addr` shows that target.
- R5: `addr` changes only on the clock after `addr_latch` is high. It holds its value during shifting.
- R6: When `addr_latch` is high, `addr` takes the register contents as they were before that clock edge. Repeated strobes without shifting leave `addr` unchanged.
- R7: While `shift_en` is low, the register, the carry flip-flop and the bit position all hold. `jump_sel` and `ser_din` are ignored during that time. A pass split by idle clocks gives the same result as an unbroken pass.
- R8: A pass that follows a jump increments from the loaded value. The carry-in is forced to one again at bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_en | input | 1 | Shift the register by one bit on this clock |
| jump_sel | input | 1 | Take the shifted-in bit from `ser_din` instead of the half adder |
| ser_din | input | 1 | Serial jump target bit, LSB first |
| addr_latch | input | 1 | Copy the register into the address latch |
| addr | output | 16 | Latched program counter, used as the memory address |

## Verification
Each shift takes effect at the next rising edge. After the last of 16 shifts, the new count reaches `addr` one clock after `addr_latch` is sampled high. The bench drives all inputs on falling edges and pulses the strobe on the falling edge after the final shift. It reads `addr` on the following falling edge, which is one full latch stage after the strobe. While a pass is in progress, the bench checks `addr` on every falling edge against the value latched before the pass began.

// File: rtl/pc_serial_inc.sv
module pc_serial_inc #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         jump_sel,
  input  logic         ser_din,
  input  logic         addr_latch,
  output logic [W-1:0] addr
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  sr_q;
  logic [CW-1:0] bit_cnt;
  logic          inc_cy;

  wire  lsb_pos = (bit_cnt == '0);
  wire  cy_in   = lsb_pos | inc_cy;
  wire  ha_sum  = sr_q[0] ^ cy_in;
  wire  ha_cout = sr_q[0] & cy_in;
  wire  new_bit = jump_sel ? ser_din : ha_sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q    <= '0;
      bit_cnt <= '0;
      inc_cy  <= 1'b0;
    end else if (shift_en) begin
      sr_q    <= {new_bit, sr_q[W-1:1]};
      inc_cy  <= jump_sel ? 1'b0 : ha_cout;
      bit_cnt <= (bit_cnt == CW'(W-1)) ? '0 : bit_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr <= '0;
    else if (addr_latch) addr <= sr_q;
  end
endmodule

// File: rtl/pc_serial_inc_chk.sv
module pc_serial_inc_chk #(
  parameter int W  = 16,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          shift_en,
  input logic          jump_sel,
  input logic          ser_din,
  input logic          addr_latch,
  input logic [W-1:0]  addr,
  input logic [W-1:0]  sr_q,
  input logic [CW-1:0] bit_cnt
);
  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_latch |=> $stable(addr));

  assert_latch_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    addr_latch |=> addr == $past(sr_q));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> ($stable(sr_q) && $stable(bit_cnt)));

  assert_lsb_plus_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !jump_sel && bit_cnt == '0) |=> sr_q[W-1] == ~$past(sr_q[0]));

  assert_jump_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && jump_sel) |=> sr_q[W-1] == $past(ser_din));
endmodule

bind pc_serial_inc pc_serial_inc_chk #(.W(W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .jump_sel(jump_sel),
  .ser_din(ser_din), .addr_latch(addr_latch), .addr(addr),
  .sr_q(sr_q), .bit_cnt(bit_cnt)
);

// File: tb/sim_pc_serial_inc.sv
module sim_pc_serial_inc;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shift_en = 1'b0, jump_sel = 1'b0, ser_din = 1'b0, addr_latch = 1'b0;
  logic [15:0] addr;
  int tests = 0, fails = 0;
  logic [15:0] model = 16'h0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pc_serial_inc u0 (.clk(clk), .rst_n(rst_n), .shift_en(shift_en), .jump_sel(jump_sel),
                    .ser_din(ser_din), .addr_latch(addr_latch), .addr(addr));

  task automatic check(input string req, input logic [15:0] exp);
    tests++;
    if (addr !== exp) begin
      fails++;
      $display("FAIL %s: addr=%h expected=%h", req, addr, exp);
    end
  endtask

  task automatic pass(input bit jmp, input logic [15:0] tgt, input int idle, input string req);
    logic [15:0] held = addr;
    bit moved = 1'b0;
    for (int i = 0; i < 16; i++) begin
      for (int k = 0; k < idle; k++) begin
        @(negedge clk);
        shift_en = 1'b0; jump_sel = ~jmp; ser_din = ~tgt[i];
      end
      @(negedge clk);
      if (addr !== held) moved = 1'b1;
      shift_en = 1'b1; jump_sel = jmp; ser_din = tgt[i];
    end
    @(negedge clk);
    shift_en = 1'b0; jump_sel = 1'b0;
    tests++;
    if (moved || addr !== held) begin
      fails++;
      $display("FAIL R5: addr=%h expected=%h during shifting", addr, held);
    end
    addr_latch = 1'b1;
    @(negedge clk);
    addr_latch = 1'b0;
    model = jmp ? tgt : model + 16'h1;
    check(req, model);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 16'h0000);
    pass(1'b0, 16'h0, 0, "R1 first increment");
    for (int n = 0; n < 5; n++) pass(1'b0, 16'h0, 0, "R2 increment");
    for (int b = 1; b <= 16; b++) begin
      pass(1'b1, 16'((32'h1 << b) - 1), 0, "R4 jump");
      pass(1'b0, 16'h0, 0, "R8 increment after jump");
    end
    pass(1'b1, 16'hFFFE, 0, "R4 jump");
    pass(1'b0, 16'h0, 0, "R2 to FFFF");
    pass(1'b0, 16'h0, 0, "R3 wrap");
    pass(1'b1, 16'hA5C3, 2, "R7 jump with idle gaps");
    pass(1'b0, 16'h0, 3, "R7 increment with idle gaps");
    repeat (3) begin
      @(negedge clk); addr_latch = 1'b1;
      @(negedge clk); addr_latch = 1'b0;
      check("R6 repeated strobe", model);
    end
    pass(1'b1, 16'hFF80, 0, "R4 jump");
    for (int n = 0; n < 200; n++) pass(1'b0, 16'h0, 0, "R2 sweep across wrap");
    pass(1'b1, 16'h1234, 0, "R4 jump");
    pass(1'b0, 16'h0, 1, "R8 increment");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule